// File: doc/BRIEF.md
# Reset Cause Recorder

This block keeps four sticky flags that say which reset source caused the most recent restart. Boot firmware reads them to tell a cold power-up from a warm restart, and clears the flags it has handled. The four sources are power-on reset, an external reset pin, a watchdog expiry that counts only while the watchdog reset-enable control is 1, and a digitised brown-out indication that is high while the supply is below the brown-out threshold.

Each source has its own rule for which other flags it sets, clears or leaves alone. The flags live in the always-on domain. Only the power-on input resets them. The external, watchdog and brown-out inputs each pass through a two-flop synchroniser and an edge detector, so one event sets its flag once. Software clears flags through a write-one-to-clear port. The read port returns the flags zero-extended to a 32-bit word.

Flag positions in the read word: bit 0 power-on, bit 1 external pin, bit 2 watchdog, bit 3 brown-out. Bits 31..4 read as zero.

Top module: `rst_cause_reg`

## Requirements
- R1: While `por_n` is low at a clock edge, the flags become 0x1: power-on set, the other three cleared. This clears a stale brown-out flag.
- R2: The power-on flag (bit 0) is never set by the external, watchdog or brown-out inputs. Once cleared, it stays 0 until the next power-on reset.
- R3: A rising edge on `ext_rst_in` sets bit 1 and clears bit 2. It leaves bits 0 and 3 unchanged.
- R4: A rising edge on `wdt_expire` while `wdt_rst_en` is 1 sets bit 2 and leaves the other bits unchanged.
- R5: A rising edge on `wdt_expire` while `wdt_rst_en` is 0 has no effect on any flag.
- R6: A brown-out recovery (`bod_low` falls after being high) sets bit 3 and clears bit 2, leaving bits 0 and 1. A drop (`bod_low` rising) alone changes no flag.
- R7: An input already high when `por_n` is released is seen as a new event after the release. An external pin still asserted sets bit 1. A supply rising from below the brown-out threshold sets bit 3.
- R8: When `wr_en` is 1, each bit of `wr_mask` that is 1 clears the matching flag, and each bit that is 0 leaves it unchanged.
- R9: If a hardware set and a software clear target the same flag in the same cycle, the set wins.
- R10: A level held high sets its flag once. After software clears the flag, it stays 0 while the level stays high.
- R11: `rd_data` always equals the four flags zero-extended to 32 bits.
- R12: A change on `ext_rst_in`, `wdt_expire` or `bod_low` driven between clock edges affects the flags at the third rising edge after the change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| por_n | input | 1 | Power-on reset, active low, sampled synchronously |
| ext_rst_in | input | 1 | External reset pin level, active high, asynchronous |
| wdt_expire | input | 1 | Watchdog expiry, active high, asynchronous |
| wdt_rst_en | input | 1 | Watchdog reset-enable control, same clock domain |
| bod_low | input | 1 | Supply below brown-out threshold, active high, asynchronous |
| wr_en | input | 1 | Write strobe for the clear mask |
| wr_mask | input | 4 | Write-one-to-clear mask, one bit per flag |
| rd_data | output | 32 | Flags zero-extended to a bus word |

## Verification
The assertions assume that `por_n` is low from time zero until the clock has run a few edges. They also assume that `wdt_rst_en` is steady for the cycles in which a watchdog edge crosses the synchroniser. A stable enable lets the qualified event be judged against one value of the enable.

The bench holds `por_n` low from the start. It sets the enable at least three edges before it pulses the expiry input. It drives every asynchronous input and every write on the falling clock edge, so each change has a well-defined arrival edge.

// File: rtl/rcs_pkg.sv
// Package: shared widths and flag positions for the reset cause recorder.
// Assumes: flag order is fixed because firmware decodes bit positions.
package rcs_pkg;
    localparam int NFLAG    = 4;
    localparam int BUS_W    = 32;
    localparam int NSRC     = 3;
    localparam int F_POR    = 0;
    localparam int F_EXT    = 1;
    localparam int F_WDT    = 2;
    localparam int F_BOD    = 3;
    // source lanes inside the event front end
    localparam int S_EXT    = 0;
    localparam int S_WDT    = 1;
    localparam int S_BOD    = 2;
    // which lanes fire on a falling edge (brown-out recovery)
    localparam logic [NSRC-1:0] FALL_MAP = 3'b100;
endpackage

// File: rtl/rcs_sync.sv
// Module: rcs_sync
// Purpose: multi-flop synchroniser followed by a one-cycle edge detector.
// Assumes: STAGES >= 2; por_n is a synchronous active-low clear that
// empties the chain, so a level still high after release reads as an edge.
module rcs_sync #(
    parameter int STAGES = 2,
    parameter bit FALL   = 1'b0
) (
    input  logic clk,
    input  logic por_n,
    input  logic din,
    output logic evt
);
    logic [STAGES-1:0] chain;
    logic              hist;
    logic              synced;

    assign synced = chain[STAGES-1];

    // Shift the asynchronous input through the chain and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            chain <= '0;
            hist  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            hist  <= synced;
        end
    end

    // Pick the edge polarity this lane reports.
    generate
        if (FALL) begin : g_fall
            assign evt = hist & ~synced;
        end else begin : g_rise
            assign evt = synced & ~hist;
        end
    endgenerate

    // One event per transition: a held level never produces back-to-back pulses.
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!por_n)
        evt |=> !evt);
endmodule

// File: rtl/rcs_events.sv
// Module: rcs_events
// Purpose: synchronises the three asynchronous reset sources and turns them
// into single-cycle events; qualifies the watchdog event with its enable.
// Assumes: wdt_rst_en is already in the clk domain.
module rcs_events
    import rcs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic ext_rst_in,
    input  logic wdt_expire,
    input  logic wdt_rst_en,
    input  logic bod_low,
    output logic ev_ext,
    output logic ev_wdt,
    output logic ev_bod
);
    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] evt;

    assign raw[S_EXT] = ext_rst_in;
    assign raw[S_WDT] = wdt_expire;
    assign raw[S_BOD] = bod_low;

    // One synchroniser lane per source; polarity chosen per lane.
    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_lane
            rcs_sync #(
                .STAGES (STAGES),
                .FALL   (FALL_MAP[g])
            ) u_sync (
                .clk   (clk),
                .por_n (por_n),
                .din   (raw[g]),
                .evt   (evt[g])
            );
        end
    endgenerate

    assign ev_ext = evt[S_EXT];
    assign ev_wdt = evt[S_WDT] & wdt_rst_en;
    assign ev_bod = evt[S_BOD];

    // A disabled watchdog never produces a reset event.
    assert_wdt_gated_R5: assert property (@(posedge clk) disable iff (!por_n)
        !wdt_rst_en |-> !ev_wdt);
endmodule

// File: rtl/rcs_flags.sv
// Module: rcs_flags
// Purpose: the four sticky cause flags with per-source set/clear rules and
// write-one-to-clear from software; hardware set beats software clear.
// Assumes: events are single-cycle pulses in the clk domain.
module rcs_flags
    import rcs_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             ev_ext,
    input  logic             ev_wdt,
    input  logic             ev_bod,
    input  logic             wr_en,
    input  logic [NFLAG-1:0] wr_mask,
    output logic [NFLAG-1:0] flags
);
    logic [NFLAG-1:0] hw_set;
    logic [NFLAG-1:0] hw_clr;
    logic [NFLAG-1:0] sw_clr;
    logic [NFLAG-1:0] flags_nxt;

    // Decode which flags each event sets and which it knocks down.
    always_comb begin
        hw_set        = '0;
        hw_clr        = '0;
        hw_set[F_EXT] = ev_ext;
        hw_set[F_WDT] = ev_wdt;
        hw_set[F_BOD] = ev_bod;
        hw_clr[F_WDT] = ev_ext | ev_bod;
        sw_clr        = wr_en ? wr_mask : '0;
    end

    // Clears first, sets last, so a set in the same cycle wins.
    assign flags_nxt = (flags & ~hw_clr & ~sw_clr) | hw_set;

    // Flag storage; only power-on reset initialises it.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            flags <= NFLAG'(1) << F_POR;
        end else begin
            flags <= flags_nxt;
        end
    end

    // Power-on flag never comes back without a power-on reset.
    assert_por_only_R2: assert property (@(posedge clk) disable iff (!por_n)
        !flags[F_POR] |=> !flags[F_POR]);

    // External event clears the watchdog flag unless a watchdog set coincides.
    assert_ext_clears_wdt_R3: assert property (@(posedge clk) disable iff (!por_n)
        (ev_ext && !ev_wdt) |=> !flags[F_WDT]);

    // External event leaves the brown-out flag alone.
    assert_ext_keeps_bod_R3: assert property (@(posedge clk) disable iff (!por_n)
        (ev_ext && !ev_bod && !(wr_en && wr_mask[F_BOD])) |=> (flags[F_BOD] == $past(flags[F_BOD])));

    // Recovery clears the watchdog flag and keeps the external flag.
    assert_bod_rules_R6: assert property (@(posedge clk) disable iff (!por_n)
        (ev_bod && !ev_wdt && !ev_ext && !wr_en) |=> (!flags[F_WDT] && flags[F_EXT] == $past(flags[F_EXT])));

    // With no event and no write the flags hold.
    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!por_n)
        (!wr_en && !ev_ext && !ev_wdt && !ev_bod) |=> $stable(flags));

    // Per-flag checks for the sourced bits.
    generate
        for (genvar b = 1; b < NFLAG; b++) begin : g_chk
            assert_set_wins_R9: assert property (@(posedge clk) disable iff (!por_n)
                hw_set[b] |=> flags[b]);
            assert_w1c_R8: assert property (@(posedge clk) disable iff (!por_n)
                (wr_en && wr_mask[b] && !hw_set[b]) |=> !flags[b]);
        end
    endgenerate
endmodule

// File: rtl/rst_cause_reg.sv
// Module: rst_cause_reg (top)
// Purpose: reset cause recorder; synchronised event front end feeding the
// sticky flag register, read back zero-extended on a 32-bit word.
// Assumes: clk runs during power-on reset; por_n is synchronous active low.
module rst_cause_reg
    import rcs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               ext_rst_in,
    input  logic               wdt_expire,
    input  logic               wdt_rst_en,
    input  logic               bod_low,
    input  logic               wr_en,
    input  logic [NFLAG-1:0]   wr_mask,
    output logic [BUS_W-1:0]   rd_data
);
    logic             ev_ext;
    logic             ev_wdt;
    logic             ev_bod;
    logic [NFLAG-1:0] flags;

    // Front end: synchronise and edge-detect the asynchronous sources.
    rcs_events #(
        .STAGES (SYNC_STAGES)
    ) u_events (
        .clk        (clk),
        .por_n      (por_n),
        .ext_rst_in (ext_rst_in),
        .wdt_expire (wdt_expire),
        .wdt_rst_en (wdt_rst_en),
        .bod_low    (bod_low),
        .ev_ext     (ev_ext),
        .ev_wdt     (ev_wdt),
        .ev_bod     (ev_bod)
    );

    // Sticky flag storage with set/clear rules.
    rcs_flags u_flags (
        .clk     (clk),
        .por_n   (por_n),
        .ev_ext  (ev_ext),
        .ev_wdt  (ev_wdt),
        .ev_bod  (ev_bod),
        .wr_en   (wr_en),
        .wr_mask (wr_mask),
        .flags   (flags)
    );

    // Read path: zero-extend the flags.
    assign rd_data = {{(BUS_W-NFLAG){1'b0}}, flags};

    // After a power-on reset cycle the read word shows only the power-on flag.
    assert_por_state_R1: assert property (@(posedge clk)
        !por_n |=> (rd_data == 32'h1));
endmodule

// File: tb/rst_cause_reg_tb.sv
module rst_cause_reg_tb;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        ext_rst_in = 1'b0;
    logic        wdt_expire = 1'b0;
    logic        wdt_rst_en = 1'b0;
    logic        bod_low = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_mask = 4'h0;
    logic [31:0] rd_data;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    rst_cause_reg u_dut (
        .clk        (clk),
        .por_n      (por_n),
        .ext_rst_in (ext_rst_in),
        .wdt_expire (wdt_expire),
        .wdt_rst_en (wdt_rst_en),
        .bod_low    (bod_low),
        .wr_en      (wr_en),
        .wr_mask    (wr_mask),
        .rd_data    (rd_data)
    );

    task automatic check(input string req, input logic [31:0] exp);
        total++;
        if (rd_data !== exp) begin
            bad++;
            $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
        end
    endtask

    // n rising edges, then settle on the falling edge
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic sw_clear(input logic [3:0] m);
        wr_en = 1'b1; wr_mask = m;
        tick(1);
        wr_en = 1'b0; wr_mask = 4'h0;
    endtask

    task automatic wdt_pulse();
        wdt_expire = 1'b1;
        tick(1);
        wdt_expire = 1'b0;
        tick(2);
    endtask

    task automatic t_reset();
        tick(3);
        check("R1 reset state", 32'h1);
        por_n = 1'b1;
        tick(2);
        check("R11 idle after release", 32'h1);
    endtask

    task automatic t_w1c();
        sw_clear(4'h0);
        check("R8 write zero keeps", 32'h1);
        sw_clear(4'h1);
        check("R8 R2 clear power-on flag", 32'h0);
    endtask

    task automatic t_ext_latency();
        ext_rst_in = 1'b1;
        tick(2);
        check("R12 not yet after two edges", 32'h0);
        tick(1);
        check("R3 R12 ext sets bit1 on third edge", 32'h2);
        ext_rst_in = 1'b0;
        tick(3);
        check("R3 falling pin no effect", 32'h2);
    endtask

    task automatic t_wdt();
        wdt_rst_en = 1'b0;
        tick(3);
        wdt_pulse();
        tick(1);
        check("R5 disabled watchdog ignored", 32'h2);
        wdt_rst_en = 1'b1;
        tick(3);
        wdt_pulse();
        check("R4 watchdog sets bit2", 32'h6);
    endtask

    task automatic t_bod();
        bod_low = 1'b1;
        tick(4);
        check("R6 drop alone no change", 32'h6);
        bod_low = 1'b0;
        tick(3);
        check("R6 recovery sets bit3 clears bit2", 32'hA);
        ext_rst_in = 1'b1;
        tick(3);
        check("R3 R2 ext keeps bit3 and bit0", 32'hA);
        ext_rst_in = 1'b0;
        tick(3);
    endtask

    task automatic t_collision();
        sw_clear(4'h2);
        check("R8 clear bit1", 32'h8);
        ext_rst_in = 1'b1;
        tick(2);
        wr_en = 1'b1; wr_mask = 4'h2;
        tick(1);
        wr_en = 1'b0; wr_mask = 4'h0;
        check("R9 set beats clear", 32'hA);
    endtask

    task automatic t_held();
        sw_clear(4'h2);
        tick(5);
        check("R10 held level sets once", 32'h8);
        ext_rst_in = 1'b0;
        tick(3);
        check("R10 release no effect", 32'h8);
    endtask

    task automatic t_ext_clears_wdt();
        wdt_pulse();
        check("R4 watchdog again", 32'hC);
        ext_rst_in = 1'b1;
        tick(3);
        check("R3 ext clears bit2", 32'hA);
    endtask

    task automatic t_por_held();
        bod_low = 1'b1;
        por_n = 1'b0;
        tick(2);
        check("R1 power-on clears stale bits", 32'h1);
        por_n = 1'b1;
        tick(3);
        check("R7 pin held across release", 32'h3);
        bod_low = 1'b0;
        tick(3);
        check("R7 R6 rising supply sets bit3", 32'hB);
        ext_rst_in = 1'b0;
        tick(2);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_w1c();
        t_ext_latency();
        t_wdt();
        t_bod();
        t_collision();
        t_held();
        t_ext_clears_wdt();
        t_por_held();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog: cycles=%0d expected=%0d", cycles, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule